// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits beside the fetch stage of an in-order 32-bit core. It removes the compare-and-branch instructions at the bottom of counted loops. Software programs a loop set with three values: a first-instruction address, a last-instruction address and a trip count. After that, the block watches every fetched PC. When the fetched PC equals the last address of a running set and more trips remain, the block asks fetch to jump back to the first address in the same cycle. It then takes one off the count. On the final trip it makes no request, so fetch carries on sequentially past the loop.

There are two loop sets, so two loops can nest. Set 0 is the inner set and has priority. Each value can be written on its own, from either the register operand or the immediate operand. A combined quick setup takes the address of the setup instruction: the loop starts at that address plus 4 and ends at the start plus an offset, and the count is loaded in the same command. Each set runs a two-state machine. SET_IDLE moves to SET_LOOP when a nonzero count is written. SET_LOOP moves back to SET_IDLE when its final trip is fetched or when a count of zero is written. A count write or quick setup in any state reloads the count.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, `loop_active` is 0 and `redirect_valid` is 0, whatever PC is fetched.
- R2: A command with `cmd_op` 0 writes the start address, 1 writes the end address and 2 writes the count of set `cmd_set`. The operand is `cmd_imm_val` when `cmd_use_imm`=1 and `cmd_reg_val` otherwise. A nonzero count sets that set's bit in `loop_active` on the next cycle (bit i belongs to set i).
- R3: `cmd_op` 3 (quick setup) sets start to `cmd_pc`+4, sets end to start+`cmd_offset`, and loads the count from the selected operand in one command.
- R4: While a set is active with a count above 1, a fetch (`fetch_valid`=1) of its end address raises `redirect_valid` in that same cycle with `redirect_target` equal to its start, and the count falls by one at the next edge. A count of N therefore gives N-1 redirects.
- R5: When the end address is fetched with a count of 1, no redirect is made (fetch falls through to end+4), and the set is inactive from the next cycle.
- R6: When both sets share an end address, set 0 is served first. Set 1 redirects at that address only in a fetch where set 0 is inactive or is finishing its last trip.
- R7: Writing a count of 0 leaves the set inactive, or makes it inactive if it was running.
- R8: Start and end addresses may take any 32-bit value, including unaligned ones and the all-ones address.
- R9: With `fetch_valid`=0 there is no redirect and no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | 32 | Address of the instruction being fetched |
| fetch_valid | input | 1 | Fetch advances with `fetch_pc` this cycle |
| cmd_valid | input | 1 | Setup command present |
| cmd_op | input | 2 | 0 start, 1 end, 2 count, 3 quick setup |
| cmd_set | input | 1 | Target loop set (0 inner, 1 outer) |
| cmd_use_imm | input | 1 | 1 selects immediate operand, 0 register operand |
| cmd_reg_val | input | 32 | Register operand |
| cmd_imm_val | input | 32 | Immediate operand |
| cmd_pc | input | 32 | Address of the setup instruction (quick setup) |
| cmd_offset | input | 32 | End offset from start (quick setup) |
| redirect_valid | output | 1 | Fetch must jump to `redirect_target` |
| redirect_target | output | 32 | Loop start address to fetch next |
| loop_active | output | 2 | Per-set running flag |

## Verification
The embedded properties check on every cycle that a running set never holds a zero count, that each loop-back lowers the count by exactly one, that a final trip or a zero count write leaves the set idle, that nothing moves without a fetch strobe, and that a redirect always leaves some set running. Only the directed scenarios can show the end-to-end trip counts and the redirect targets. The same holds for the order of targets in a shared-end nest, the operand selection, the quick-setup address arithmetic and the behaviour at unaligned and wrap-edge addresses.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_END   = 2'd1,
        OP_COUNT = 2'd2,
        OP_SETUP = 2'd3
    } hwl_op_e;

    typedef enum logic {
        SET_IDLE = 1'b0,
        SET_LOOP = 1'b1
    } set_state_e;

endpackage

// File: rtl/hwloop_set.sv
module hwloop_set
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_end,
    input  logic              wr_count,
    input  logic [ADDR_W-1:0] wdata_start,
    input  logic [ADDR_W-1:0] wdata_end,
    input  logic [CNT_W-1:0]  wdata_count,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              fetch_valid,
    input  logic              take,
    output logic              active,
    output logic              hit,
    output logic              last,
    output logic [ADDR_W-1:0] start_addr
);

    set_state_e        state_q, state_d;
    logic [ADDR_W-1:0] start_q, end_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_any;

    assign wr_any = wr_start | wr_end | wr_count;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SET_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SET_IDLE: if (wr_count && wdata_count != '0) state_d = SET_LOOP;
            SET_LOOP: begin
                if (wr_count)          state_d = (wdata_count == '0) ? SET_IDLE : SET_LOOP;
                else if (take && last) state_d = SET_IDLE;
            end
            default:  state_d = SET_IDLE;
        endcase
    end

    // loop registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (wr_start) start_q <= wdata_start;
            if (wr_end)   end_q   <= wdata_end;
            if (wr_count)           cnt_q <= wdata_count;
            else if (take && !last) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        active     = (state_q == SET_LOOP);
        last       = (cnt_q == CNT_W'(1));
        hit        = active && fetch_valid && !wr_any && (fetch_pc == end_q);
        start_addr = start_q;
    end

    AST_ACTIVE_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> cnt_q != '0); // R7
    AST_LOOPBACK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !last && !wr_any) |=> (active && cnt_q == $past(cnt_q) - CNT_W'(1))); // R4
    AST_LAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last && !wr_any) |=> !active); // R5
    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count && wdata_count == '0) |=> !active); // R7
    AST_HOLD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !wr_any) |=> ($stable(cnt_q) && $stable(state_q))); // R9

endmodule

// File: rtl/hwloop_arb.sv
module hwloop_arb #(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 32
) (
    input  logic [NUM_SETS-1:0]             hit,
    input  logic [NUM_SETS-1:0]             last,
    input  logic [NUM_SETS-1:0][ADDR_W-1:0] starts,
    output logic [NUM_SETS-1:0]             take,
    output logic                            redirect_valid,
    output logic [ADDR_W-1:0]               redirect_target
);

    logic blocked;

    // inner set (lowest index) first; a finishing set passes the fetch outward
    always_comb begin
        take            = '0;
        redirect_valid  = 1'b0;
        redirect_target = '0;
        blocked         = 1'b0;
        for (int i = 0; i < NUM_SETS; i++) begin
            if (!blocked && hit[i]) begin
                take[i] = 1'b1;
                if (!last[i]) begin
                    redirect_valid  = 1'b1;
                    redirect_target = starts[i];
                    blocked         = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [ADDR_W-1:0]                           fetch_pc,
    input  logic                                        fetch_valid,
    input  logic                                        cmd_valid,
    input  logic [1:0]                                  cmd_op,
    input  logic [((NUM_SETS > 1) ? $clog2(NUM_SETS) : 1)-1:0] cmd_set,
    input  logic                                        cmd_use_imm,
    input  logic [ADDR_W-1:0]                           cmd_reg_val,
    input  logic [ADDR_W-1:0]                           cmd_imm_val,
    input  logic [ADDR_W-1:0]                           cmd_pc,
    input  logic [ADDR_W-1:0]                           cmd_offset,
    output logic                                        redirect_valid,
    output logic [ADDR_W-1:0]                           redirect_target,
    output logic [NUM_SETS-1:0]                         loop_active
);

    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

    hwl_op_e                        op;
    logic [ADDR_W-1:0]              operand;
    logic [ADDR_W-1:0]              start_val, end_val;
    logic [CNT_W-1:0]               cnt_val;
    logic [NUM_SETS-1:0]            hit_v, last_v, take_v;
    logic [NUM_SETS-1:0][ADDR_W-1:0] start_v;

    // command decode
    always_comb begin
        op        = hwl_op_e'(cmd_op);
        operand   = cmd_use_imm ? cmd_imm_val : cmd_reg_val;
        cnt_val   = operand[CNT_W-1:0];
        start_val = (op == OP_SETUP) ? cmd_pc + ADDR_W'(4) : operand;
        end_val   = (op == OP_SETUP) ? cmd_pc + ADDR_W'(4) + cmd_offset : operand;
    end

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        logic sel;
        assign sel = cmd_valid && (cmd_set == SET_W'(g));

        hwloop_set #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_set (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_start    (sel && (op == OP_START || op == OP_SETUP)),
            .wr_end      (sel && (op == OP_END   || op == OP_SETUP)),
            .wr_count    (sel && (op == OP_COUNT || op == OP_SETUP)),
            .wdata_start (start_val),
            .wdata_end   (end_val),
            .wdata_count (cnt_val),
            .fetch_pc    (fetch_pc),
            .fetch_valid (fetch_valid),
            .take        (take_v[g]),
            .active      (loop_active[g]),
            .hit         (hit_v[g]),
            .last        (last_v[g]),
            .start_addr  (start_v[g])
        );
    end

    hwloop_arb #(
        .NUM_SETS (NUM_SETS),
        .ADDR_W   (ADDR_W)
    ) u_arb (
        .hit             (hit_v),
        .last            (last_v),
        .starts          (start_v),
        .take            (take_v),
        .redirect_valid  (redirect_valid),
        .redirect_target (redirect_target)
    );

    AST_REDIRECT_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> fetch_valid); // R9
    AST_REDIRECT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !cmd_valid) |=> (loop_active != '0)); // R4
    AST_INNER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v[0] && !last_v[0]) |-> ($countones(take_v) == 1 && take_v[0])); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!redirect_valid && loop_active == '0)); // R1

endmodule

// File: tb/hwloop_ctrl_test.sv
module hwloop_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_valid = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [0:0]  cmd_set = '0;
    logic        cmd_use_imm = 1'b0;
    logic [31:0] cmd_reg_val = '0, cmd_imm_val = '0, cmd_pc = '0, cmd_offset = '0;
    logic        redirect_valid;
    logic [31:0] redirect_target;
    logic [1:0]  loop_active;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    int nredir;
    logic [31:0] tgts [8];

    always #2.5 clk = ~clk;

    hwloop_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_set(cmd_set), .cmd_use_imm(cmd_use_imm),
        .cmd_reg_val(cmd_reg_val), .cmd_imm_val(cmd_imm_val), .cmd_pc(cmd_pc),
        .cmd_offset(cmd_offset), .redirect_valid(redirect_valid),
        .redirect_target(redirect_target), .loop_active(loop_active)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmd(logic [1:0] op, bit set, bit imm, logic [31:0] rv, logic [31:0] iv,
                       logic [31:0] pc, logic [31:0] off);
        @(negedge clk);
        fetch_valid = 1'b0;
        cmd_valid = 1'b1; cmd_op = op; cmd_set = set; cmd_use_imm = imm;
        cmd_reg_val = rv; cmd_imm_val = iv; cmd_pc = pc; cmd_offset = off;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // one fetch at pc; sampled 1 ns after the falling edge
    task automatic fetch(logic [31:0] pc, bit v);
        @(negedge clk);
        fetch_pc = pc; fetch_valid = v;
        #1;
    endtask

    task automatic run(logic [31:0] first, logic [31:0] stop);
        logic [31:0] pc = first;
        nredir = 0;
        for (int s = 0; s < 64 && pc != stop; s++) begin
            fetch(pc, 1'b1);
            if (redirect_valid) begin
                if (nredir < 8) tgts[nredir] = redirect_target;
                nredir++;
                pc = redirect_target;
            end else begin
                pc = pc + 32'd4;
            end
        end
        @(negedge clk);
        fetch_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        #1;
        check("R1 active", {30'd0, loop_active}, 32'd0);
        check("R1 redirect", {31'd0, redirect_valid}, 32'd0);
        fetch(32'd0, 1'b1);
        check("R1 redirect at pc0", {31'd0, redirect_valid}, 32'd0);
    endtask

    task automatic t_individual();
        cmd(2'd0, 1'b0, 1'b0, 32'h100, 32'h999, 32'd0, 32'd0);
        cmd(2'd1, 1'b0, 1'b1, 32'h777, 32'h10C, 32'd0, 32'd0);
        cmd(2'd2, 1'b0, 1'b0, 32'd3,   32'd7,   32'd0, 32'd0);
        #1;
        check("R2 active after count", {30'd0, loop_active}, 32'd1);
        run(32'h100, 32'h110);
        check("R2 R4 redirects for count 3", nredir, 32'd2);
        check("R4 target", tgts[0], 32'h100);
        check("R5 inactive after last trip", {30'd0, loop_active}, 32'd0);
    endtask

    task automatic t_fast();
        cmd(2'd3, 1'b1, 1'b1, 32'd9, 32'd4, 32'h200, 32'd8);
        #1;
        check("R3 set1 active", {30'd0, loop_active}, 32'd2);
        run(32'h204, 32'h210);
        check("R3 redirects for count 4", nredir, 32'd3);
        check("R3 start is pc+4", tgts[2], 32'h204);
        check("R5 set1 idle", {30'd0, loop_active}, 32'd0);
    endtask

    task automatic t_zero();
        cmd(2'd2, 1'b0, 1'b1, 32'd5, 32'd0, 32'd0, 32'd0);
        #1;
        check("R7 zero count stays idle", {30'd0, loop_active}, 32'd0);
        fetch(32'h10C, 1'b1);
        check("R7 no redirect at end", {31'd0, redirect_valid}, 32'd0);
        cmd(2'd3, 1'b0, 1'b0, 32'd5, 32'd0, 32'h700, 32'd4);
        #1;
        check("R7 running before zero", {30'd0, loop_active}, 32'd1);
        cmd(2'd2, 1'b0, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0);
        #1;
        check("R7 zero stops running set", {30'd0, loop_active}, 32'd0);
        fetch(32'h708, 1'b1);
        check("R7 no redirect after stop", {31'd0, redirect_valid}, 32'd0);
    endtask

    task automatic t_nested();
        cmd(2'd0, 1'b1, 1'b0, 32'h400, 32'd0, 32'd0, 32'd0);
        cmd(2'd1, 1'b1, 1'b0, 32'h40C, 32'd0, 32'd0, 32'd0);
        cmd(2'd2, 1'b1, 1'b0, 32'd3,   32'd0, 32'd0, 32'd0);
        cmd(2'd0, 1'b0, 1'b1, 32'd0, 32'h404, 32'd0, 32'd0);
        cmd(2'd1, 1'b0, 1'b1, 32'd0, 32'h40C, 32'd0, 32'd0);
        cmd(2'd2, 1'b0, 1'b1, 32'd0, 32'd2,   32'd0, 32'd0);
        run(32'h400, 32'h410);
        check("R6 redirect count", nredir, 32'd3);
        check("R6 inner first", tgts[0], 32'h404);
        check("R6 outer after inner done", tgts[1], 32'h400);
        check("R6 outer again", tgts[2], 32'h400);
        check("R6 both idle", {30'd0, loop_active}, 32'd0);
    endtask

    task automatic t_anyaddr();
        cmd(2'd0, 1'b0, 1'b0, 32'h3,        32'd0, 32'd0, 32'd0);
        cmd(2'd1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'd0, 32'd0, 32'd0);
        cmd(2'd2, 1'b0, 1'b0, 32'd2,        32'd0, 32'd0, 32'd0);
        fetch(32'hFFFFFFFF, 1'b1);
        check("R8 redirect at all-ones end", {31'd0, redirect_valid}, 32'd1);
        check("R8 unaligned target", redirect_target, 32'h3);
        fetch(32'hFFFFFFFF, 1'b1);
        check("R8 last trip falls through", {31'd0, redirect_valid}, 32'd0);
        cmd(2'd3, 1'b1, 1'b1, 32'd0, 32'd2, 32'h501, 32'd7);
        fetch(32'h50C, 1'b1);
        check("R8 R3 odd quick setup redirect", {31'd0, redirect_valid}, 32'd1);
        check("R8 R3 odd quick setup target", redirect_target, 32'h505);
        fetch(32'h50C, 1'b1);
        check("R8 odd set finished", {31'd0, redirect_valid}, 32'd0);
        @(negedge clk); fetch_valid = 1'b0;
    endtask

    task automatic t_novalid();
        cmd(2'd3, 1'b0, 1'b1, 32'd0, 32'd2, 32'h5FC, 32'd8);
        for (int k = 0; k < 3; k++) begin
            fetch(32'h608, 1'b0);
            check("R9 no redirect without strobe", {31'd0, redirect_valid}, 32'd0);
        end
        fetch(32'h608, 1'b1);
        check("R9 count kept: still redirects", {31'd0, redirect_valid}, 32'd1);
        check("R9 target", redirect_target, 32'h600);
        fetch(32'h608, 1'b1);
        check("R9 R5 second fetch is last", {31'd0, redirect_valid}, 32'd0);
        @(negedge clk); fetch_valid = 1'b0; #1;
        check("R9 R5 idle", {30'd0, loop_active}, 32'd0);
    endtask

    initial begin
        #12 rst_n = 1'b1;
        t_reset();
        t_individual();
        t_fast();
        t_zero();
        t_nested();
        t_anyaddr();
        t_novalid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule